// File: doc/BRIEF.md
# Serial Receiver with Status-Tagged Two-Entry Queue

This block is the receive half of an asynchronous serial port. It watches the RX line for a falling edge, times each bit from an oversampling tick, and votes on three samples taken in the middle of every bit. Frames of 8 or 9 data bits are shifted in LSB first and closed by a stop bit. Each finished frame goes into a two-entry circular queue. Every entry carries the data byte, the ninth data bit, a framing-error flag and an overrun flag.

Software sees the head entry at all times: an available flag, the three status bits, and the data byte. Software should read the status first and then pulse the pop input. The pop takes the entry away together with its status. When both queue entries are occupied, a finished frame stays in the shift stage as a third level. It moves into the queue as soon as a slot frees up. An overrun happens only when a new start bit arrives while the queue is full and the shift stage still holds its frame. In that case the held frame is lost, and the next entry to reach the queue carries the overrun flag.

The oversampling tick comes from outside. Its rate is 16 ticks per bit in normal mode and 8 ticks per bit in double-speed mode. Baud generation and transmission are not part of this block.

Top module: `serq_rx`

## Requirements
- R1: After reset, avail_o, ferr_o, ovr_o, bit8_o and data_o are all 0.
- R2: In 8-bit mode (nine_bit_i=0) a frame is start bit, eight data bits LSB first, then a stop bit. The byte appears on data_o with avail_o=1, and bit8_o is 0.
- R3: In 9-bit mode (nine_bit_i=1) the ninth data bit, received after bit 7, appears on bit8_o of that entry.
- R4: If the stop bit votes low, ferr_o is 1 for that entry and the data byte is still delivered. If the stop bit votes high, ferr_o is 0.
- R5: An overrun is recorded only when a start bit is detected while both queue entries are full and the shift stage holds a finished frame. That held frame is discarded. The next entry to enter the queue has ovr_o=1, and entries already queued keep ovr_o=0.
- R6: A falling edge is taken as a start bit only while rx_en_i is 1. Dropping rx_en_i abandons a frame in progress. Frames sent while rx_en_i is 0 produce no entry.
- R7: The queue holds two entries in arrival order. The status outputs always belong to the head entry. A pop_i pulse removes the head entry. A pop while the queue is empty has no effect.
- R8: A frame that finishes while the queue is full waits in the shift stage. It enters the queue after the next pop, in order and with ovr_o=0, provided no start bit arrived in the meantime.
- R9: With dbl_speed_i=1 a bit lasts 8 ticks. The samples are ticks 3, 4 and 5 of the bit, counted from tick 0 at start detection.
- R10: In normal mode a bit lasts 16 ticks. The bit value is the 2-of-3 majority of ticks 7, 8 and 9, so a single disturbed sample does not change the bit.
- R11: If the start bit votes high, the receiver returns to idle and no entry is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, idle high |
| rx_en_i | input | 1 | Receiver enable |
| os_tick_i | input | 1 | Oversampling tick, one clock wide |
| dbl_speed_i | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| pop_i | input | 1 | Removes the head entry |
| avail_o | output | 1 | Queue holds at least one entry |
| data_o | output | 8 | Head entry data byte |
| bit8_o | output | 1 | Head entry ninth data bit |
| ferr_o | output | 1 | Head entry framing error |
| ovr_o | output | 1 | Head entry overrun |

## Verification
The hardest state to reach is the overrun. Both queue entries must be full, the shift stage must be holding a frame, and a fourth start bit must then arrive before any pop. The bench sends four back-to-back frames without popping to create this state. It then pops step by step: the two oldest entries should show no overrun, and the fourth frame should arrive flagged. The bench also exercises the vote directly. It places a glitch one tick wide at the centre of a bit, so that the glitch covers exactly one of the three sample ticks.

// File: rtl/serq_pkg.sv
package serq_pkg;

    localparam int BYTE_W   = 8;
    localparam int MAX_BITS = BYTE_W + 1;

    typedef struct packed {
        logic              ferr;
        logic              bit8;
        logic [BYTE_W-1:0] data;
    } serq_frame_t;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              bit8;
        logic [BYTE_W-1:0] data;
    } serq_entry_t;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_STOP
    } serq_rxs_e;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/serq_deframer.sv
module serq_deframer
    import serq_pkg::*;
#(
    parameter int OS_NORM = 16,
    parameter int OS_DBL  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_i,
    input  logic        en_i,
    input  logic        tick_i,
    input  logic        dbl_i,
    input  logic        nine_i,
    output logic        start_o,
    output logic        done_o,
    output serq_frame_t frame_o
);

    localparam int CNT_W  = $clog2(OS_NORM);
    localparam int BIDX_W = $clog2(MAX_BITS + 1);

    serq_rxs_e             state;
    logic [CNT_W-1:0]      cnt;
    logic [BIDX_W-1:0]     bit_idx;
    logic [MAX_BITS-1:0]   shreg;
    logic [2:0]            votes;
    logic                  rx_prev;

    logic [CNT_W-1:0]      bit_last_tick;
    logic [CNT_W-1:0]      mid_tick;
    logic [BIDX_W-1:0]     last_bit;
    logic                  bit_val;
    logic                  stop_val;

    assign bit_last_tick = dbl_i ? CNT_W'(OS_DBL - 1) : CNT_W'(OS_NORM - 1);
    assign mid_tick      = dbl_i ? CNT_W'(OS_DBL / 2) : CNT_W'(OS_NORM / 2);
    assign last_bit      = nine_i ? BIDX_W'(MAX_BITS - 1) : BIDX_W'(BYTE_W - 1);
    assign bit_val       = vote3(votes);
    assign stop_val      = vote3({rx_i, votes[1:0]});

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RXS_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            votes   <= '0;
            rx_prev <= 1'b1;
            start_o <= 1'b0;
            done_o  <= 1'b0;
            frame_o <= '0;
        end else begin
            start_o <= 1'b0;
            done_o  <= 1'b0;
            if (tick_i) begin
                rx_prev <= rx_i;
                if (state == RXS_IDLE) begin
                    if (en_i && rx_prev && !rx_i) begin
                        state   <= RXS_START;
                        cnt     <= CNT_W'(1);
                        start_o <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + CNT_W'(1);
                    if (cnt == mid_tick - CNT_W'(1)) votes[0] <= rx_i;
                    if (cnt == mid_tick)             votes[1] <= rx_i;
                    if (cnt == mid_tick + CNT_W'(1)) votes[2] <= rx_i;
                    unique case (state)
                        RXS_START: begin
                            if (cnt == bit_last_tick) begin
                                cnt     <= '0;
                                bit_idx <= '0;
                                state   <= bit_val ? RXS_IDLE : RXS_DATA;
                            end
                        end
                        RXS_DATA: begin
                            if (cnt == bit_last_tick) begin
                                cnt     <= '0;
                                shreg   <= {bit_val, shreg[MAX_BITS-1:1]};
                                bit_idx <= bit_idx + BIDX_W'(1);
                                if (bit_idx == last_bit) state <= RXS_STOP;
                            end
                        end
                        RXS_STOP: begin
                            if (cnt == mid_tick + CNT_W'(1)) begin
                                done_o        <= 1'b1;
                                frame_o.ferr  <= !stop_val;
                                frame_o.bit8  <= nine_i & shreg[MAX_BITS-1];
                                frame_o.data  <= nine_i ? shreg[BYTE_W-1:0]
                                                        : shreg[MAX_BITS-1:1];
                                state         <= RXS_IDLE;
                            end
                        end
                        default: state <= RXS_IDLE;
                    endcase
                end
            end
            if (!en_i) state <= RXS_IDLE;
        end
    end

    AST_START_WHEN_ENABLED: assert property (@(posedge clk) disable iff (rst)
        start_o |-> $past(en_i)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R4

endmodule

// File: rtl/serq_holdstage.sv
module serq_holdstage
    import serq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        done_i,
    input  serq_frame_t frame_i,
    input  logic        full_i,
    output logic        push_o,
    output serq_entry_t entry_o
);

    logic        held;
    logic        lost;
    serq_frame_t hold_frame;

    always_comb begin
        push_o  = 1'b0;
        entry_o = '0;
        if (held && !full_i) begin
            push_o        = 1'b1;
            entry_o.ovr   = lost;
            entry_o.ferr  = hold_frame.ferr;
            entry_o.bit8  = hold_frame.bit8;
            entry_o.data  = hold_frame.data;
        end else if (done_i && !full_i) begin
            push_o        = 1'b1;
            entry_o.ovr   = lost;
            entry_o.ferr  = frame_i.ferr;
            entry_o.bit8  = frame_i.bit8;
            entry_o.data  = frame_i.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held       <= 1'b0;
            lost       <= 1'b0;
            hold_frame <= '0;
        end else begin
            if (held && !full_i) begin
                held <= 1'b0;
                lost <= 1'b0;
            end else if (done_i && !full_i) begin
                lost <= 1'b0;
            end else if (done_i && full_i) begin
                held       <= 1'b1;
                hold_frame <= frame_i;
            end
            if (start_i && held && full_i) begin
                held <= 1'b0;
                lost <= 1'b1;
            end
        end
    end

    AST_LOSS_NEEDS_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(lost) |-> $past(start_i && held && full_i)); // R5
    AST_HELD_WAITS: assert property (@(posedge clk) disable iff (rst)
        (held && full_i && !start_i) |=> held); // R8

endmodule

// File: rtl/serq_fifo.sv
module serq_fifo
    import serq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push_i,
    input  serq_entry_t entry_i,
    input  logic        pop_i,
    output serq_entry_t head_o,
    output logic        valid_o,
    output logic        full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    serq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              pop_eff;

    assign valid_o = (count != '0);
    assign full_o  = (count == CNT_W'(DEPTH));
    assign pop_eff = pop_i && valid_o;
    assign head_o  = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push_i) begin
                mem[wr_ptr] <= entry_i;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop_eff) rd_ptr <= nxt(rd_ptr);
            if (push_i && !pop_eff)      count <= count + CNT_W'(1);
            else if (!push_i && pop_eff) count <= count - CNT_W'(1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o); // R8
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !valid_o && !push_i) |=> !valid_o); // R7

endmodule

// File: rtl/serq_rx.sv
module serq_rx
    import serq_pkg::*;
#(
    parameter int DEPTH   = 2,
    parameter int OS_NORM = 16,
    parameter int OS_DBL  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_i,
    input  logic              rx_en_i,
    input  logic              os_tick_i,
    input  logic              dbl_speed_i,
    input  logic              nine_bit_i,
    input  logic              pop_i,
    output logic              avail_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              bit8_o,
    output logic              ferr_o,
    output logic              ovr_o
);

    logic        start_p;
    logic        done_p;
    serq_frame_t frame;
    logic        push;
    serq_entry_t entry;
    serq_entry_t head;
    logic        valid;
    logic        full;

    serq_deframer #(.OS_NORM(OS_NORM), .OS_DBL(OS_DBL)) u_defr (
        .clk     (clk),
        .rst     (rst),
        .rx_i    (rx_i),
        .en_i    (rx_en_i),
        .tick_i  (os_tick_i),
        .dbl_i   (dbl_speed_i),
        .nine_i  (nine_bit_i),
        .start_o (start_p),
        .done_o  (done_p),
        .frame_o (frame)
    );

    serq_holdstage u_hold (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_p),
        .done_i  (done_p),
        .frame_i (frame),
        .full_i  (full),
        .push_o  (push),
        .entry_o (entry)
    );

    serq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .entry_i (entry),
        .pop_i   (pop_i),
        .head_o  (head),
        .valid_o (valid),
        .full_o  (full)
    );

    assign avail_o = valid;
    assign data_o  = valid ? head.data : '0;
    assign bit8_o  = valid & head.bit8;
    assign ferr_o  = valid & head.ferr;
    assign ovr_o   = valid & head.ovr;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!avail_o && !bit8_o)); // R1

endmodule

// File: tb/sim_serq_rx.sv
module sim_serq_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx = 1'b1;
    logic       en = 1'b1;
    logic       tick = 1'b0;
    logic       dbl = 1'b0;
    logic       nine = 1'b0;
    logic       pop = 1'b0;
    logic       avail;
    logic [7:0] data;
    logic       bit8;
    logic       ferr;
    logic       ovr;

    int n_checks = 0;
    int n_fail   = 0;
    int bitclk   = 64;
    bit done_flag = 0;

    always #2 clk = ~clk;

    serq_rx u0 (
        .clk(clk), .rst(rst), .rx_i(rx), .rx_en_i(en), .os_tick_i(tick),
        .dbl_speed_i(dbl), .nine_bit_i(nine), .pop_i(pop),
        .avail_o(avail), .data_o(data), .bit8_o(bit8), .ferr_o(ferr), .ovr_o(ovr)
    );

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_head(input string tag, input int v, input int d,
                               input int b8, input int fe, input int ov);
        chk({tag, " avail"}, avail, v);
        chk({tag, " data"},  data,  d);
        chk({tag, " bit8"},  bit8,  b8);
        chk({tag, " ferr"},  ferr,  fe);
        chk({tag, " ovr"},   ovr,   ov);
    endtask

    task automatic hold_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] val, input int nbits, input logic stop_lvl);
        rx = 1'b0; hold_clks(bitclk);
        for (int i = 0; i < nbits; i++) begin
            rx = val[i]; hold_clks(bitclk);
        end
        rx = stop_lvl; hold_clks(bitclk);
        rx = 1'b1; hold_clks(bitclk);
    endtask

    task automatic do_pop();
        pop = 1'b1; @(negedge clk);
        pop = 1'b0; hold_clks(3);
    endtask

    task automatic t_reset();
        expect_head("R1 reset", 0, 0, 0, 0, 0);
    endtask

    task automatic t_basic8();
        send(9'h0A5, 8, 1'b1);
        expect_head("R2 byte A5", 1, 8'hA5, 0, 0, 0);
        do_pop();
        chk("R2 empty after pop", avail, 0);
    endtask

    task automatic t_nine();
        nine = 1'b1;
        send(9'h13C, 9, 1'b1);
        expect_head("R3 ninth bit set", 1, 8'h3C, 1, 0, 0);
        do_pop();
        send(9'h0C3, 9, 1'b1);
        expect_head("R3 ninth bit clear", 1, 8'hC3, 0, 0, 0);
        do_pop();
        nine = 1'b0;
    endtask

    task automatic t_ferr();
        send(9'h05A, 8, 1'b0);
        expect_head("R4 bad stop", 1, 8'h5A, 0, 1, 0);
        do_pop();
    endtask

    task automatic t_order();
        do_pop();
        chk("R7 pop on empty", avail, 0);
        send(9'h081, 8, 1'b0);
        send(9'h042, 8, 1'b1);
        expect_head("R7 head first", 1, 8'h81, 0, 1, 0);
        do_pop();
        expect_head("R7 head second", 1, 8'h42, 0, 0, 0);
        do_pop();
        chk("R7 drained", avail, 0);
    endtask

    task automatic t_third();
        send(9'h001, 8, 1'b1);
        send(9'h002, 8, 1'b1);
        send(9'h003, 8, 1'b1);
        expect_head("R8 head", 1, 8'h01, 0, 0, 0);
        do_pop();
        expect_head("R8 second", 1, 8'h02, 0, 0, 0);
        do_pop();
        expect_head("R8 held frame", 1, 8'h03, 0, 0, 0);
        do_pop();
        chk("R8 drained", avail, 0);
    endtask

    task automatic t_overrun();
        send(9'h011, 8, 1'b1);
        send(9'h022, 8, 1'b1);
        send(9'h033, 8, 1'b1);
        send(9'h044, 8, 1'b1);
        expect_head("R5 oldest clean", 1, 8'h11, 0, 0, 0);
        do_pop();
        expect_head("R5 second clean", 1, 8'h22, 0, 0, 0);
        do_pop();
        expect_head("R5 flagged survivor", 1, 8'h44, 0, 0, 1);
        do_pop();
        chk("R5 drained", avail, 0);
    endtask

    task automatic t_disable();
        en = 1'b0;
        send(9'h0F0, 8, 1'b1);
        chk("R6 disabled no entry", avail, 0);
        en = 1'b1;
        rx = 1'b0; hold_clks(bitclk * 3);
        en = 1'b0; hold_clks(8);
        rx = 1'b1; hold_clks(bitclk * 10);
        en = 1'b1; hold_clks(bitclk);
        chk("R6 aborted frame no entry", avail, 0);
        send(9'h077, 8, 1'b1);
        expect_head("R6 re-enabled", 1, 8'h77, 0, 0, 0);
        do_pop();
    endtask

    task automatic t_dbl();
        dbl = 1'b1; bitclk = 32;
        send(9'h0B4, 8, 1'b1);
        expect_head("R9 double speed", 1, 8'hB4, 0, 0, 0);
        do_pop();
        dbl = 1'b0; bitclk = 64;
    endtask

    task automatic t_vote();
        logic [7:0] v;
        v = 8'h20;
        rx = 1'b0; hold_clks(bitclk);
        for (int i = 0; i < 8; i++) begin
            rx = v[i];
            if (i == 3 || i == 5) begin
                hold_clks(32); rx = ~v[i]; hold_clks(4); rx = v[i]; hold_clks(28);
            end else begin
                hold_clks(bitclk);
            end
        end
        rx = 1'b1; hold_clks(bitclk * 2);
        expect_head("R10 glitch outvoted", 1, 8'h20, 0, 0, 0);
        do_pop();
    endtask

    task automatic t_false_start();
        rx = 1'b0; hold_clks(8);
        rx = 1'b1; hold_clks(bitclk * 12);
        chk("R11 short low pulse", avail, 0);
        send(9'h0E1, 8, 1'b1);
        expect_head("R11 recovers", 1, 8'hE1, 0, 0, 0);
        do_pop();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        hold_clks(6);
        t_reset();
        rst = 1'b0;
        hold_clks(bitclk);
        t_reset();
        t_basic8();
        t_nine();
        t_ferr();
        t_order();
        t_third();
        t_overrun();
        t_disable();
        t_dbl();
        t_vote();
        t_false_start();
        finish_run();
    end

endmodule